// File: doc/BRIEF.md
# Address Translation Cache with Event-Driven Invalidation

This block is a small fully associative cache of page translations. Each slot pairs a virtual page number with a physical page number and carries a global attribute. A lookup is purely combinational: the block compares the presented virtual page against every valid slot in the same cycle and returns a hit flag together with the physical page. A fill port writes new translations. A fill goes to the lowest free slot, rewrites a slot that already holds the same page, or evicts a slot chosen in rotation when none is free.

Several system events can discard cached translations. Some of them spare slots marked global and others clear the whole array. A targeted command removes a single page, whatever its global attribute. The block keeps its own copy of the page-table base, so it can tell whether a task switch actually changes the base. It edge-detects the external flush pin. For control-register writes it compares old and new values and clears the array only when one of the relevant flag bits flips. When an invalidation and a fill arrive in the same cycle, the invalidation is applied first, so the new translation survives.

Top module: `tlb_inval`

## Requirements
- R1: A lookup returns hit=1 and the stored physical page in the same cycle when a valid slot holds the presented virtual page, and returns hit=0 otherwise.
- R2: A fill takes the lowest-indexed invalid slot. When all 8 slots are valid, it replaces the slot named by a rotating pointer that is 0 after reset and advances by one, wrapping, on each such replacement.
- R3: A fill whose virtual page is already cached rewrites that slot in place, and every other slot stays cached.
- R4: A single-page invalidate clears only the slot that holds the given virtual page, whether or not that slot is global.
- R5: A write to the page-table base clears every non-global slot and keeps every global slot.
- R6: A task switch clears the non-global slots only when its base differs from the held page-table base, and then loads the new base. The held base is 0 after reset, and a task switch with an equal base changes nothing.
- R7: Each change of level on the flush pin, rising or falling, clears every slot. Holding the pin at a steady level clears nothing further. The previous level is taken as 0 at reset.
- R8: A memory-type-range write clears every slot, including global ones.
- R9: A control-register-0 write clears every slot when bit 0 (protection enable) or bit 31 (paging enable) differs between the old and new values. It clears nothing when only other bits differ.
- R10: A control-register-4 write clears every slot when bit 4 (page-size extension), bit 5 (physical-address extension) or bit 7 (global-page enable) differs between the old and new values. It clears nothing when only other bits differ.
- R11: When an invalidation event and a fill occur in the same cycle, the invalidation is applied first, and the filled translation is valid afterwards.
- R12: After reset, no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 20 | Virtual page to look up |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page on hit, 0 on miss |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_ppn | input | 20 | Physical page of the fill |
| fill_glb | input | 1 | Global attribute of the fill |
| inv_page_en | input | 1 | Single-page invalidate |
| inv_page_vpn | input | 20 | Page to invalidate |
| ptb_wr | input | 1 | Page-table base write |
| ptb_wdata | input | 32 | New page-table base |
| ts_en | input | 1 | Task switch |
| ts_base | input | 32 | Base loaded by the task switch |
| flush_pin | input | 1 | External flush pin level |
| mtrr_wr | input | 1 | Memory-type-range register write |
| cr0_wr | input | 1 | Control register 0 write |
| cr0_old | input | 32 | Value before the write |
| cr0_new | input | 32 | Value after the write |
| cr4_wr | input | 1 | Control register 4 write |
| cr4_old | input | 32 | Value before the write |
| cr4_new | input | 32 | Value after the write |

## Verification
A lookup is combinational, so its result is due in the same cycle as the lookup input. Fills, invalidations and flush-pin level changes take effect at the next rising edge, so their effect shows on lookups from the cycle after that edge. The bench drives each event just after a rising edge and releases it just after the following edge. It then sets the lookup page between edges and samples the hit and page outputs a short delay later, well before the next edge. Because of this, every check sees exactly one edge's worth of state change.

// File: rtl/tlb_inval.sv
module tlb_inval #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int CR_W    = 32,
  parameter int CR0_PE  = 0,
  parameter int CR0_PG  = 31,
  parameter int CR4_PSE = 4,
  parameter int CR4_PAE = 5,
  parameter int CR4_PGE = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_glb,
  input  logic             inv_page_en,
  input  logic [VPN_W-1:0] inv_page_vpn,
  input  logic             ptb_wr,
  input  logic [CR_W-1:0]  ptb_wdata,
  input  logic             ts_en,
  input  logic [CR_W-1:0]  ts_base,
  input  logic             flush_pin,
  input  logic             mtrr_wr,
  input  logic             cr0_wr,
  input  logic [CR_W-1:0]  cr0_old,
  input  logic [CR_W-1:0]  cr0_new,
  input  logic             cr4_wr,
  input  logic [CR_W-1:0]  cr4_old,
  input  logic [CR_W-1:0]  cr4_new
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q, glb_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [CR_W-1:0]                ptb_q;
  logic                           pin_q;
  logic [IW-1:0]                  rr_q;

  logic [ENTRIES-1:0] lk_match, surv, fmatch;
  logic [PPN_W-1:0]   lk_ppn_c;
  logic [IW-1:0]      tgt;
  logic               use_rr;

  wire cr0_flip = cr0_wr && ((cr0_old[CR0_PE] ^ cr0_new[CR0_PE]) ||
                             (cr0_old[CR0_PG] ^ cr0_new[CR0_PG]));
  wire cr4_flip = cr4_wr && ((cr4_old[CR4_PSE] ^ cr4_new[CR4_PSE]) ||
                             (cr4_old[CR4_PAE] ^ cr4_new[CR4_PAE]) ||
                             (cr4_old[CR4_PGE] ^ cr4_new[CR4_PGE]));
  wire kill_all   = (flush_pin ^ pin_q) | mtrr_wr | cr0_flip | cr4_flip;
  wire kill_local = ptb_wr | (ts_en && (ts_base != ptb_q));

  always_comb begin
    lk_ppn_c = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
      lk_ppn_c    = lk_ppn_c | ({PPN_W{lk_match[i]}} & ppn_q[i]);
      surv[i]     = valid_q[i] && !kill_all && !(kill_local && !glb_q[i]) &&
                    !(inv_page_en && (vpn_q[i] == inv_page_vpn));
      fmatch[i]   = surv[i] && (vpn_q[i] == fill_vpn);
    end
  end

  assign lk_hit = |lk_match;
  assign lk_ppn = lk_ppn_c;
  assign use_rr = ~|fmatch & (&surv);

  always_comb begin
    tgt = rr_q;
    if (|fmatch) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (fmatch[i]) tgt = IW'(i);
    end else if (!use_rr) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!surv[i]) tgt = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      glb_q   <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      ptb_q   <= '0;
      pin_q   <= 1'b0;
      rr_q    <= '0;
    end else begin
      pin_q   <= flush_pin;
      valid_q <= surv;
      if (ptb_wr)     ptb_q <= ptb_wdata;
      else if (ts_en) ptb_q <= ts_base;
      if (fill_en) begin
        valid_q[tgt] <= 1'b1;
        vpn_q[tgt]   <= fill_vpn;
        ppn_q[tgt]   <= fill_ppn;
        glb_q[tgt]   <= fill_glb;
        if (use_rr) rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end
endmodule

module tlb_inval_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int CR_W    = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [VPN_W-1:0]              lk_vpn,
  input logic                          fill_en,
  input logic                          inv_page_en,
  input logic                          ptb_wr,
  input logic                          ts_en,
  input logic [CR_W-1:0]               ts_base,
  input logic                          flush_pin,
  input logic                          pin_q,
  input logic                          mtrr_wr,
  input logic                          cr0_wr,
  input logic                          cr0_pe_flip,
  input logic                          cr4_wr,
  input logic [ENTRIES-1:0]            valid_q,
  input logic [ENTRIES-1:0]            glb_q,
  input logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  input logic [CR_W-1:0]               ptb_q
);
  logic [ENTRIES-1:0] seen;
  always_comb
    for (int i = 0; i < ENTRIES; i++)
      seen[i] = valid_q[i] && (vpn_q[i] == lk_vpn);

  wire quiet = !fill_en && !inv_page_en && !mtrr_wr && !cr0_wr && !cr4_wr &&
               (flush_pin == pin_q);

  assert_unique_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seen));

  assert_ptb_keeps_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb_wr && quiet) |=> (valid_q == $past(valid_q & glb_q)));

  assert_ts_same_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_en && !ptb_wr && (ts_base == ptb_q) && quiet) |=> $stable(valid_q));

  assert_pin_edge_wipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_pin != pin_q) && !fill_en) |=> (valid_q == '0));

  assert_mtrr_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mtrr_wr && !fill_en) |=> (valid_q == '0));

  assert_cr0_pe_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cr0_wr && cr0_pe_flip && !fill_en) |=> (valid_q == '0));

  assert_fill_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> ($countones(valid_q) >= 1));
endmodule

bind tlb_inval tlb_inval_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CR_W(CR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .fill_en(fill_en),
  .inv_page_en(inv_page_en), .ptb_wr(ptb_wr), .ts_en(ts_en), .ts_base(ts_base),
  .flush_pin(flush_pin), .pin_q(pin_q), .mtrr_wr(mtrr_wr), .cr0_wr(cr0_wr),
  .cr0_pe_flip(cr0_old[CR0_PE] ^ cr0_new[CR0_PE]), .cr4_wr(cr4_wr),
  .valid_q(valid_q), .glb_q(glb_q), .vpn_q(vpn_q), .ptb_q(ptb_q)
);

// File: tb/tlb_inval_bench.sv
module tlb_inval_bench;
  logic        clk = 0, rst_n = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, fill_ppn = 0, inv_page_vpn = 0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic        fill_en = 0, fill_glb = 0, inv_page_en = 0, ptb_wr = 0, ts_en = 0;
  logic        flush_pin = 0, mtrr_wr = 0, cr0_wr = 0, cr4_wr = 0;
  logic [31:0] ptb_wdata = 0, ts_base = 0, cr0_old = 0, cr0_new = 0, cr4_old = 0, cr4_new = 0;
  int total = 0, bad = 0;
  bit done = 0;

  tlb_inval u_tlb_inval (.*);

  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk); #2;
    fill_en = 0; inv_page_en = 0; ptb_wr = 0; ts_en = 0;
    mtrr_wr = 0; cr0_wr = 0; cr4_wr = 0;
  endtask

  task automatic hit(string req, logic [19:0] vpn, logic [19:0] ppn);
    lk_vpn = vpn; #1; total++;
    if (!lk_hit || lk_ppn !== ppn) begin
      bad++;
      $display("FAIL %s vpn=%h: act hit=%b ppn=%h exp hit=1 ppn=%h", req, vpn, lk_hit, lk_ppn, ppn);
    end
  endtask

  task automatic miss(string req, logic [19:0] vpn);
    lk_vpn = vpn; #1; total++;
    if (lk_hit !== 1'b0) begin
      bad++;
      $display("FAIL %s vpn=%h: act hit=%b exp hit=0", req, vpn, lk_hit);
    end
  endtask

  task automatic fill(logic [19:0] v, logic [19:0] p, logic g);
    fill_en = 1; fill_vpn = v; fill_ppn = p; fill_glb = g; step();
  endtask

  task automatic wipe();
    mtrr_wr = 1; step();
  endtask

  task automatic fill_set();
    for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), 20'h200 + 20'(i), (i % 2) == 0);
  endtask

  task automatic expect_globals_only(string req);
    for (int i = 0; i < 8; i++)
      if (i % 2 == 0) hit(req, 20'h100 + 20'(i), 20'h200 + 20'(i));
      else miss(req, 20'h100 + 20'(i));
  endtask

  task automatic expect_all(string req);
    for (int i = 0; i < 8; i++) hit(req, 20'h100 + 20'(i), 20'h200 + 20'(i));
  endtask

  task automatic expect_none(string req);
    for (int i = 0; i < 8; i++) miss(req, 20'h100 + 20'(i));
  endtask

  task automatic t_reset();
    miss("R12", 20'h0); miss("R12", 20'h100); miss("R12", 20'hFFFFF);
  endtask

  task automatic t_lookup();
    fill_set();
    expect_all("R1");
    miss("R1", 20'h999);
  endtask

  task automatic t_rotate();
    hit("R2", 20'h107, 20'h207);
    fill(20'h300, 20'h3AA, 0);
    miss("R2", 20'h100); hit("R2", 20'h300, 20'h3AA); hit("R2", 20'h101, 20'h201);
    fill(20'h301, 20'h3BB, 0);
    miss("R2", 20'h101); hit("R2", 20'h301, 20'h3BB); hit("R2", 20'h102, 20'h202);
    wipe();
  endtask

  task automatic t_update();
    fill_set();
    fill(20'h105, 20'h555, 0);
    hit("R3", 20'h105, 20'h555);
    for (int i = 0; i < 8; i++) if (i != 5) hit("R3", 20'h100 + 20'(i), 20'h200 + 20'(i));
    wipe();
  endtask

  task automatic t_page();
    fill_set();
    inv_page_en = 1; inv_page_vpn = 20'h100; step();
    miss("R4", 20'h100);
    inv_page_en = 1; inv_page_vpn = 20'h103; step();
    miss("R4", 20'h103);
    for (int i = 1; i < 8; i++) if (i != 3) hit("R4", 20'h100 + 20'(i), 20'h200 + 20'(i));
    wipe();
  endtask

  task automatic t_ptb();
    fill_set();
    ptb_wr = 1; ptb_wdata = 32'h1234; step();
    expect_globals_only("R5");
    wipe();
  endtask

  task automatic t_ts();
    fill_set();
    ts_en = 1; ts_base = 32'h1234; step();
    expect_all("R6");
    ts_en = 1; ts_base = 32'h5678; step();
    expect_globals_only("R6");
    wipe(); fill_set();
    ts_en = 1; ts_base = 32'h5678; step();
    expect_all("R6");
    wipe();
  endtask

  task automatic t_pin();
    fill_set();
    flush_pin = 1; step();
    expect_none("R7");
    fill_set(); step(); step();
    expect_all("R7");
    flush_pin = 0; step();
    expect_none("R7");
  endtask

  task automatic t_mtrr();
    fill_set();
    wipe();
    expect_none("R8");
  endtask

  task automatic t_cr0();
    fill_set();
    cr0_wr = 1; cr0_old = 32'h0; cr0_new = 32'h7FFF_FFFE; step();
    expect_all("R9");
    cr0_wr = 1; cr0_old = 32'h0; cr0_new = 32'h1; step();
    expect_none("R9");
    fill_set();
    cr0_wr = 1; cr0_old = 32'h8000_0000; cr0_new = 32'h0; step();
    expect_none("R9");
  endtask

  task automatic t_cr4();
    fill_set();
    cr4_wr = 1; cr4_old = 32'h0; cr4_new = 32'hFFFF_FF4F; step();
    expect_all("R10");
    foreach (cr4_new[b]) if (b == 4 || b == 5 || b == 7) begin
      cr4_wr = 1; cr4_old = 32'h0; cr4_new = 32'h1 << b; step();
      expect_none("R10");
      fill_set();
    end
    wipe();
  endtask

  task automatic t_same_cycle();
    fill_set();
    ptb_wr = 1; ptb_wdata = 32'h9; fill(20'h400, 20'h4AA, 0);
    hit("R11", 20'h400, 20'h4AA); miss("R11", 20'h101); hit("R11", 20'h100, 20'h200);
    mtrr_wr = 1; fill(20'h500, 20'h5AA, 1);
    hit("R11", 20'h500, 20'h5AA); miss("R11", 20'h100); miss("R11", 20'h400);
    inv_page_en = 1; inv_page_vpn = 20'h500; fill(20'h500, 20'h5BB, 0);
    hit("R11", 20'h500, 20'h5BB);
    wipe();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_lookup();
    t_rotate();
    t_update();
    t_page();
    t_ptb();
    t_ts();
    t_pin();
    t_mtrr();
    t_cr0();
    t_cr4();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule